// File: doc/BRIEF.md
# UART Side-Band Pin Controller

This block handles the three side-band pins that sit next to a UART data path. The first is a clear-to-send input. It either gates the transmitter as a flow-control signal or serves as a plain readable input. The second is a request-to-send output, active low. The receive path drives it from its FIFO status, or software drives it directly. The third is one general-purpose pin that can take one of four roles:
- an edge-watching input;
- an output driven by software;
- an external bit-clock input feeding the baud generator;
- an output carrying the bit clock the baud generator produces.

Both input pins pass through a synchronizer before edge detection. A transition in either direction on the clear-to-send pin raises a sticky interrupt flag. A transition on the general-purpose pin raises one only while that pin is in input mode. Software masks the flags and clears them with write-one-to-clear strobes. The request line reports whether the receiver can take more data. It also negates early when the receiver signals that an overrun is about to happen. The baud generator and the FIFOs sit outside this block and connect only through the status, clock and tick signals listed below.

Top module: `uart_sideband_ctrl`

## Requirements
- R1: After reset `rts_n_o` is 1, `gpio_oe_o`, `irq_flags_o`, `irq_o` and `tx_allow_o` are 0. With `rts_sw_sel_i`=0, `rts_n_o` is 0 one cycle after `rx_fifo_full_i`=0 and `rx_overrun_pend_i`=0. It is 1 one cycle after `rx_fifo_full_i`=1.
- R2: With `rts_sw_sel_i`=0, `rts_n_o` is 1 one cycle after `rx_overrun_pend_i`=1, even when the FIFO is not full.
- R3: With `rts_sw_sel_i`=1, `rts_n_o` equals the inverse of `rts_sw_assert_i` one cycle later. FIFO full and overrun status have no effect.
- R4: `cts_level_o` shows the clear-to-send pin two cycles after a change. `tx_allow_o` is 1 one cycle after `cts_flow_en_i`=0. With flow control on, it is 1 exactly three cycles after the pin goes low and 0 three cycles after the pin goes high.
- R5: Every rising or falling edge of the clear-to-send pin sets `irq_flags_o[0]` three cycles after the pin change.
- R6: An edge on the general-purpose pin sets `irq_flags_o[1]` three cycles after the change, but only in mode 0. In every other mode no flag is set, while `gpio_level_o` still follows the pin after two cycles.
- R7: A flag stays set until a 1 on the matching bit of `irq_clr_i` clears it one cycle later. A set and a clear in the same cycle leave the flag set.
- R8: `irq_o` is 1 one cycle after any flag is set together with its bit of `irq_mask_i`, and is 0 one cycle after no such pair exists.
- R9: The `gpio_mode_i` codes are: 0 input, 1 software output, 2 external clock input, 3 bit-clock output. `gpio_oe_o` is 1 one cycle after mode 1 or 3 is selected and 0 one cycle after mode 0 or 2 is selected.
- R10: In mode 1, `gpio_pin_o` equals `gpio_sw_val_i` one cycle later. In mode 3 it equals `baud_bitclk_i` one cycle later. In modes 0 and 2 it is 0.
- R11: In mode 2, `ext_clk_o` follows the pin three cycles after a change. In any other mode it is 0 one cycle after the mode is selected.
- R12: The pin levels present while reset is applied never produce an interrupt flag once reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cts_pin_i | input | 1 | Clear-to-send pad, asynchronous, low means clear |
| cts_flow_en_i | input | 1 | 1: clear-to-send gates the transmitter |
| cts_level_o | output | 1 | Synchronized clear-to-send level |
| tx_allow_o | output | 1 | Transmitter may start a character |
| rx_fifo_full_i | input | 1 | Receiver FIFO is full |
| rx_overrun_pend_i | input | 1 | Receiver predicts an overrun |
| rts_sw_sel_i | input | 1 | 1: software owns request-to-send |
| rts_sw_assert_i | input | 1 | Software request, 1 drives the pin low |
| rts_n_o | output | 1 | Request-to-send pad, active low |
| gpio_pin_i | input | 1 | General-purpose pad input, asynchronous |
| gpio_pin_o | output | 1 | General-purpose pad output value |
| gpio_oe_o | output | 1 | General-purpose pad output enable |
| gpio_mode_i | input | 2 | Pin role, codes as in R9 |
| gpio_sw_val_i | input | 1 | Software output value |
| baud_bitclk_i | input | 1 | Bit clock from the baud generator |
| ext_clk_o | output | 1 | Synchronized external clock to the baud generator |
| gpio_level_o | output | 1 | Synchronized general-purpose level |
| irq_mask_i | input | 2 | Enable per flag, bit 0 clear-to-send, bit 1 general-purpose |
| irq_clr_i | input | 2 | Write-one-to-clear strobes, same bit order |
| irq_flags_o | output | 2 | Sticky edge flags, same bit order |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
Results fall due at fixed distances from the clock edge that samples a stimulus:
- The request line, the pad output and its enable, and the mask and clear effects on the flags appear one cycle after that edge. The interrupt line lags the flags by one further cycle.
- A pad input is visible as a level after two cycles. Its edge flag, the transmit gate and the external clock follow after three, and the interrupt line after four.

Each time the driver applies a stimulus, it queues the expected value for the exact cycle in which that value falls due. It also queues the value the signal must still hold one cycle earlier, so a result that arrives too early or too late is caught. The monitor compares only items whose due cycle matches the current cycle, away from the active edge. Any item still left in the queue at the end counts as a failure.

// File: rtl/sb_pkg.sv
package sb_pkg;

  typedef enum logic [1:0] {
    GP_IN     = 2'd0,
    GP_SWOUT  = 2'd1,
    GP_CLKIN  = 2'd2,
    GP_CLKOUT = 2'd3
  } gp_mode_e;

  localparam int unsigned IRQ_CTS  = 0;
  localparam int unsigned IRQ_GPIO = 1;
  localparam int unsigned N_IRQ    = 2;

endpackage

// File: rtl/sb_sync_edge.sv
module sb_sync_edge #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic level_o,
  output logic edge_o
);

  localparam int unsigned ARM_CNT = STAGES + 1;
  localparam int unsigned CW      = $clog2(ARM_CNT + 1);
  localparam logic [CW-1:0] ARM_VAL = CW'(ARM_CNT);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;
  logic [CW-1:0]     arm_cnt_q;
  logic              armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= {STAGES{RESET_VAL}};
      prev_q  <= RESET_VAL;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], pin_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  // edges are ignored until the chain and the history flop carry real pad data
  always_ff @(posedge clk) begin
    if (rst) begin
      arm_cnt_q <= '0;
    end else if (arm_cnt_q != ARM_VAL) begin
      arm_cnt_q <= arm_cnt_q + 1'b1;
    end
  end

  assign armed   = (arm_cnt_q == ARM_VAL);
  assign level_o = chain_q[STAGES-1];
  assign edge_o  = armed & (chain_q[STAGES-1] ^ prev_q);

endmodule

// File: rtl/sb_irq_bank.sv
module sb_irq_bank #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] flags_o,
  output logic         irq_o
);

  logic [N-1:0] flags_q;
  logic         irq_q;

  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)           flags_q[g] <= 1'b0;
      else if (set_i[g]) flags_q[g] <= 1'b1;
      else if (clr_i[g]) flags_q[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(flags_q & mask_i);
  end

  assign flags_o = flags_q;
  assign irq_o   = irq_q;

endmodule

// File: rtl/sb_rts_ctrl.sv
module sb_rts_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic fifo_full_i,
  input  logic overrun_pend_i,
  input  logic sw_sel_i,
  input  logic sw_assert_i,
  output logic rts_n_o
);

  logic rts_n_q;
  logic rts_n_d;

  always_comb begin
    if (sw_sel_i) rts_n_d = ~sw_assert_i;
    else          rts_n_d = fifo_full_i | overrun_pend_i;
  end

  always_ff @(posedge clk) begin
    if (rst) rts_n_q <= 1'b1;
    else     rts_n_q <= rts_n_d;
  end

  assign rts_n_o = rts_n_q;

endmodule

// File: rtl/sb_gpio_mux.sv
module sb_gpio_mux
  import sb_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  gp_mode_e mode_i,
  input  logic     sw_val_i,
  input  logic     bitclk_i,
  input  logic     level_i,
  input  logic     edge_i,
  output logic     pin_o,
  output logic     oe_o,
  output logic     ext_clk_o,
  output logic     irq_edge_o
);

  logic pin_d, oe_d;
  logic pin_q, oe_q, ext_q;

  always_comb begin
    pin_d = 1'b0;
    oe_d  = 1'b0;
    unique case (mode_i)
      GP_SWOUT:  begin pin_d = sw_val_i; oe_d = 1'b1; end
      GP_CLKOUT: begin pin_d = bitclk_i; oe_d = 1'b1; end
      default:   begin pin_d = 1'b0;     oe_d = 1'b0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q <= 1'b0;
      oe_q  <= 1'b0;
      ext_q <= 1'b0;
    end else begin
      pin_q <= pin_d;
      oe_q  <= oe_d;
      ext_q <= (mode_i == GP_CLKIN) & level_i;
    end
  end

  assign pin_o      = pin_q;
  assign oe_o       = oe_q;
  assign ext_clk_o  = ext_q;
  assign irq_edge_o = edge_i & (mode_i == GP_IN);

endmodule

// File: rtl/uart_sideband_ctrl.sv
module uart_sideband_ctrl
  import sb_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cts_pin_i,
  input  logic       cts_flow_en_i,
  output logic       cts_level_o,
  output logic       tx_allow_o,
  input  logic       rx_fifo_full_i,
  input  logic       rx_overrun_pend_i,
  input  logic       rts_sw_sel_i,
  input  logic       rts_sw_assert_i,
  output logic       rts_n_o,
  input  logic       gpio_pin_i,
  output logic       gpio_pin_o,
  output logic       gpio_oe_o,
  input  logic [1:0] gpio_mode_i,
  input  logic       gpio_sw_val_i,
  input  logic       baud_bitclk_i,
  output logic       ext_clk_o,
  output logic       gpio_level_o,
  input  logic [1:0] irq_mask_i,
  input  logic [1:0] irq_clr_i,
  output logic [1:0] irq_flags_o,
  output logic       irq_o
);

  localparam int unsigned NI = N_IRQ;

  logic          cts_lvl, cts_edge;
  logic          gp_lvl, gp_edge, gp_irq_edge;
  logic [NI-1:0] irq_set;
  logic          tx_allow_q;
  gp_mode_e      mode;

  assign mode = gp_mode_e'(gpio_mode_i);

  sb_sync_edge #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_cts_sync (
    .clk     (clk),
    .rst     (rst),
    .pin_i   (cts_pin_i),
    .level_o (cts_lvl),
    .edge_o  (cts_edge)
  );

  sb_sync_edge #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_gp_sync (
    .clk     (clk),
    .rst     (rst),
    .pin_i   (gpio_pin_i),
    .level_o (gp_lvl),
    .edge_o  (gp_edge)
  );

  sb_gpio_mux u_gpio_mux (
    .clk        (clk),
    .rst        (rst),
    .mode_i     (mode),
    .sw_val_i   (gpio_sw_val_i),
    .bitclk_i   (baud_bitclk_i),
    .level_i    (gp_lvl),
    .edge_i     (gp_edge),
    .pin_o      (gpio_pin_o),
    .oe_o       (gpio_oe_o),
    .ext_clk_o  (ext_clk_o),
    .irq_edge_o (gp_irq_edge)
  );

  sb_rts_ctrl u_rts (
    .clk            (clk),
    .rst            (rst),
    .fifo_full_i    (rx_fifo_full_i),
    .overrun_pend_i (rx_overrun_pend_i),
    .sw_sel_i       (rts_sw_sel_i),
    .sw_assert_i    (rts_sw_assert_i),
    .rts_n_o        (rts_n_o)
  );

  always_comb begin
    irq_set           = '0;
    irq_set[IRQ_CTS]  = cts_edge;
    irq_set[IRQ_GPIO] = gp_irq_edge;
  end

  sb_irq_bank #(.N(NI)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .set_i   (irq_set),
    .clr_i   (irq_clr_i),
    .mask_i  (irq_mask_i),
    .flags_o (irq_flags_o),
    .irq_o   (irq_o)
  );

  // clear-to-send is active low: a low pad level permits transmission
  always_ff @(posedge clk) begin
    if (rst) tx_allow_q <= 1'b0;
    else     tx_allow_q <= ~cts_flow_en_i | ~cts_lvl;
  end

  assign tx_allow_o   = tx_allow_q;
  assign cts_level_o  = cts_lvl;
  assign gpio_level_o = gp_lvl;

endmodule

// File: rtl/sb_checker.sv
module sb_checker (
  input logic       clk,
  input logic       rst,
  input logic       rx_overrun_pend_i,
  input logic       rx_fifo_full_i,
  input logic       rts_sw_sel_i,
  input logic       rts_sw_assert_i,
  input logic       rts_n_o,
  input logic [1:0] gpio_mode_i,
  input logic       gpio_oe_o,
  input logic       ext_clk_o,
  input logic [1:0] irq_mask_i,
  input logic [1:0] irq_clr_i,
  input logic [1:0] irq_flags_o,
  input logic       irq_o
);

  AST_RTS_FULL_NEGATES: assert property (@(posedge clk) disable iff (rst)
    (!rts_sw_sel_i && rx_fifo_full_i) |=> rts_n_o); // R1

  AST_RTS_OVERRUN_NEGATES: assert property (@(posedge clk) disable iff (rst)
    (!rts_sw_sel_i && rx_overrun_pend_i) |=> rts_n_o); // R2

  AST_RTS_SW_DRIVE: assert property (@(posedge clk) disable iff (rst)
    rts_sw_sel_i |=> (rts_n_o != $past(rts_sw_assert_i))); // R3

  AST_FLAG_CTS_STICKY: assert property (@(posedge clk) disable iff (rst)
    (irq_flags_o[0] && !irq_clr_i[0]) |=> irq_flags_o[0]); // R7

  AST_FLAG_GPIO_STICKY: assert property (@(posedge clk) disable iff (rst)
    (irq_flags_o[1] && !irq_clr_i[1]) |=> irq_flags_o[1]); // R7

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    ((irq_flags_o & irq_mask_i) == 2'b00) |=> !irq_o); // R8

  AST_IRQ_RAISED: assert property (@(posedge clk) disable iff (rst)
    ((irq_flags_o & irq_mask_i) != 2'b00) |=> irq_o); // R8

  AST_OE_DRIVE_MODES: assert property (@(posedge clk) disable iff (rst)
    (gpio_mode_i == 2'd1 || gpio_mode_i == 2'd3) |=> gpio_oe_o); // R9

  AST_OE_HIGHZ_MODES: assert property (@(posedge clk) disable iff (rst)
    (gpio_mode_i == 2'd0 || gpio_mode_i == 2'd2) |=> !gpio_oe_o); // R9

  AST_EXTCLK_GATED: assert property (@(posedge clk) disable iff (rst)
    (gpio_mode_i != 2'd2) |=> !ext_clk_o); // R11

endmodule

bind uart_sideband_ctrl sb_checker u_chk (.*);

// File: tb/uart_sideband_ctrl_tb.sv
`timescale 1ns/1ps
module uart_sideband_ctrl_tb;

  localparam int S_RTS = 0, S_CTSLVL = 1, S_TXALLOW = 2, S_FLAG0 = 3, S_FLAG1 = 4,
                 S_IRQ = 5, S_OE = 6, S_GPO = 7, S_EXTCLK = 8, S_GPLVL = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cts_pin_i = 1'b1, cts_flow_en_i = 1'b1;
  logic rx_fifo_full_i = 1'b0, rx_overrun_pend_i = 1'b0;
  logic rts_sw_sel_i = 1'b0, rts_sw_assert_i = 1'b0;
  logic gpio_pin_i = 1'b1, gpio_sw_val_i = 1'b0, baud_bitclk_i = 1'b0;
  logic [1:0] gpio_mode_i = 2'd0, irq_mask_i = 2'b00, irq_clr_i = 2'b00;
  logic cts_level_o, tx_allow_o, rts_n_o, gpio_pin_o, gpio_oe_o, ext_clk_o, gpio_level_o, irq_o;
  logic [1:0] irq_flags_o;

  int cyc = 0;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    int    due;
    int    sig;
    logic  exp;
    string tag;
  } exp_t;
  exp_t sb_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  uart_sideband_ctrl u_dut (.*);

  function automatic logic get_sig(int s);
    case (s)
      S_RTS:     return rts_n_o;
      S_CTSLVL:  return cts_level_o;
      S_TXALLOW: return tx_allow_o;
      S_FLAG0:   return irq_flags_o[0];
      S_FLAG1:   return irq_flags_o[1];
      S_IRQ:     return irq_o;
      S_OE:      return gpio_oe_o;
      S_GPO:     return gpio_pin_o;
      S_EXTCLK:  return ext_clk_o;
      default:   return gpio_level_o;
    endcase
  endfunction

  task automatic compare(int s, logic e, string tag);
    logic a;
    a = get_sig(s);
    checks++;
    if (a !== e) begin
      failures++;
      $display("FAIL %s sig=%0d cyc=%0d actual=%b expected=%b", tag, s, cyc, a, e);
    end
  endtask

  task automatic expect_at(int s, logic e, int lat, string tag);
    exp_t it;
    it.due = cyc + lat;
    it.sig = s;
    it.exp = e;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops the items due this cycle, sampling away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      for (int i = sb_q.size() - 1; i >= 0; i--) begin
        if (sb_q[i].due == cyc) begin
          compare(sb_q[i].sig, sb_q[i].exp, sb_q[i].tag);
          sb_q.delete(i);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : driver
    step(3);
    compare(S_RTS, 1'b1, "R1 reset rts");
    compare(S_OE, 1'b0, "R1 reset oe");
    compare(S_FLAG0, 1'b0, "R1 reset flag0");
    compare(S_IRQ, 1'b0, "R1 reset irq");
    compare(S_TXALLOW, 1'b0, "R1 reset txallow");
    rst = 1'b0;
    step(8);
    compare(S_FLAG0, 1'b0, "R12 no cts flag from reset level");
    compare(S_FLAG1, 1'b0, "R12 no gpio flag from reset level");
    compare(S_RTS, 1'b0, "R1 rts asserted when fifo has room");

    // R1 fifo full
    rx_fifo_full_i = 1'b1; expect_at(S_RTS, 1'b1, 1, "R1 full negates");
    step(1);
    rx_fifo_full_i = 1'b0; expect_at(S_RTS, 1'b0, 1, "R1 room asserts");
    step(2);

    // R2 overrun pending
    rx_overrun_pend_i = 1'b1; expect_at(S_RTS, 1'b1, 1, "R2 overrun negates");
    step(1);
    expect_at(S_RTS, 1'b1, 1, "R2 overrun held");
    step(1);
    rx_overrun_pend_i = 1'b0; expect_at(S_RTS, 1'b0, 1, "R2 overrun gone");
    step(2);

    // R3 software ownership
    rts_sw_sel_i = 1'b1; rts_sw_assert_i = 1'b1; rx_fifo_full_i = 1'b1;
    expect_at(S_RTS, 1'b0, 1, "R3 sw assert over full");
    step(1);
    rx_overrun_pend_i = 1'b1; expect_at(S_RTS, 1'b0, 1, "R3 sw ignores overrun");
    step(1);
    rts_sw_assert_i = 1'b0; expect_at(S_RTS, 1'b1, 1, "R3 sw negate");
    step(1);
    rts_sw_sel_i = 1'b0; rx_fifo_full_i = 1'b0; rx_overrun_pend_i = 1'b0;
    expect_at(S_RTS, 1'b0, 1, "R3 back to auto");
    step(2);

    // R4 / R5 clear-to-send falling edge
    irq_mask_i = 2'b01;
    cts_pin_i = 1'b0;
    expect_at(S_CTSLVL, 1'b1, 1, "R4 level not early");
    expect_at(S_CTSLVL, 1'b0, 2, "R4 level latency");
    expect_at(S_TXALLOW, 1'b0, 2, "R4 allow not early");
    expect_at(S_TXALLOW, 1'b1, 3, "R4 allow on low cts");
    expect_at(S_FLAG0, 1'b0, 2, "R5 flag not early");
    expect_at(S_FLAG0, 1'b1, 3, "R5 falling edge flag");
    expect_at(S_IRQ, 1'b1, 4, "R8 irq follows flag");
    step(6);
    irq_clr_i = 2'b01;
    expect_at(S_FLAG0, 1'b0, 1, "R7 w1c clears");
    expect_at(S_IRQ, 1'b0, 2, "R8 irq drops");
    step(1);
    irq_clr_i = 2'b00;
    step(3);
    cts_pin_i = 1'b1;
    expect_at(S_FLAG0, 1'b0, 2, "R5 rise flag not early");
    expect_at(S_FLAG0, 1'b1, 3, "R5 rising edge flag");
    expect_at(S_TXALLOW, 1'b0, 3, "R4 block on high cts");
    step(4);
    cts_flow_en_i = 1'b0; expect_at(S_TXALLOW, 1'b1, 1, "R4 flow off allows");
    step(2);
    cts_flow_en_i = 1'b1; expect_at(S_TXALLOW, 1'b0, 1, "R4 flow on blocks");
    step(2);

    // R8 mask gating with flag0 set
    irq_mask_i = 2'b00; expect_at(S_IRQ, 1'b0, 1, "R8 masked");
    step(2);
    compare(S_FLAG0, 1'b1, "R7 flag kept while masked");
    irq_mask_i = 2'b01; expect_at(S_IRQ, 1'b1, 1, "R8 unmasked");
    step(2);
    irq_clr_i = 2'b01; step(1); irq_clr_i = 2'b00;
    step(3);

    // R7 set wins over clear in the same cycle
    cts_pin_i = 1'b0;
    step(2);
    irq_clr_i = 2'b01; expect_at(S_FLAG0, 1'b1, 1, "R7 set beats clear");
    step(1);
    irq_clr_i = 2'b00; expect_at(S_FLAG0, 1'b1, 1, "R7 sticky");
    step(2);
    irq_clr_i = 2'b01; step(1); irq_clr_i = 2'b00;
    compare(S_FLAG0, 1'b0, "R7 cleared after strobe");
    step(3);

    // R6 general-purpose input edges
    irq_mask_i = 2'b10;
    gpio_pin_i = 1'b0;
    expect_at(S_GPLVL, 1'b0, 2, "R6 level latency");
    expect_at(S_FLAG1, 1'b1, 3, "R6 input mode edge flag");
    expect_at(S_IRQ, 1'b1, 4, "R8 gpio irq");
    step(6);
    irq_clr_i = 2'b10; step(1); irq_clr_i = 2'b00;
    step(3);
    gpio_mode_i = 2'd1; expect_at(S_OE, 1'b1, 1, "R9 sw output drives");
    step(1);
    gpio_pin_i = 1'b1;
    expect_at(S_GPLVL, 1'b1, 2, "R6 level tracks in output mode");
    expect_at(S_FLAG1, 1'b0, 3, "R6 no flag in output mode");
    expect_at(S_FLAG1, 1'b0, 5, "R6 no late flag");
    step(6);

    // R10 output values
    gpio_sw_val_i = 1'b1; expect_at(S_GPO, 1'b1, 1, "R10 sw value high");
    step(1);
    gpio_sw_val_i = 1'b0; expect_at(S_GPO, 1'b0, 1, "R10 sw value low");
    step(2);
    gpio_mode_i = 2'd3; baud_bitclk_i = 1'b1;
    expect_at(S_OE, 1'b1, 1, "R9 clock out drives");
    expect_at(S_GPO, 1'b1, 1, "R10 bit clock high");
    step(1);
    baud_bitclk_i = 1'b0; expect_at(S_GPO, 1'b0, 1, "R10 bit clock low");
    step(1);
    baud_bitclk_i = 1'b1; expect_at(S_GPO, 1'b1, 1, "R10 bit clock high again");
    step(2);

    // R11 external clock input
    gpio_mode_i = 2'd2;
    expect_at(S_OE, 1'b0, 1, "R9 clock in tri-state");
    expect_at(S_GPO, 1'b0, 1, "R10 zero in clock in");
    expect_at(S_EXTCLK, 1'b1, 1, "R11 ext clock passes level");
    step(2);
    gpio_pin_i = 1'b0;
    expect_at(S_EXTCLK, 1'b1, 2, "R11 ext not early");
    expect_at(S_EXTCLK, 1'b0, 3, "R11 ext latency");
    expect_at(S_FLAG1, 1'b0, 4, "R6 no flag in clock in");
    step(5);
    gpio_pin_i = 1'b1; expect_at(S_EXTCLK, 1'b1, 3, "R11 ext rises");
    step(4);
    gpio_mode_i = 2'd0;
    expect_at(S_EXTCLK, 1'b0, 1, "R11 ext gated off");
    expect_at(S_OE, 1'b0, 1, "R9 input tri-state");
    step(3);
    compare(S_FLAG1, 1'b0, "R6 no flag on mode return");

    step(10);
    if (sb_q.size() != 0) begin
      failures++;
      $display("FAIL scoreboard left %0d items actual=%0d expected=0", sb_q.size(), sb_q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule